// File: doc/BRIEF.md
# Peripheral Bus Protocol Monitor

This block is a passive observer for one APB interface. It samples the select vector, enable, direction, address, write data, byte strobes, protection bits and ready line on every rising clock edge. It reports each broken protocol rule on its own bit of a violation vector, and it never drives any bus signal. A sticky error output collects every reported violation until reset, so a debug unit or an interrupt line can watch one bit instead of the whole vector.

Each cycle, the observed signals are reduced to a bus phase:

- Idle: no select bit is high.
- Setup: a select bit is high and enable is low.
- Access: a select bit is high and enable is high.

A small tracking machine remembers what the previous cycle was. Its states are:

- `ST_RESET`: the first cycle after reset.
- `ST_IDLE`, `ST_SETUP`: the previous cycle was idle or setup.
- `ST_WAIT`: an access phase that ended without ready.
- `ST_DONE`: an access phase that completed.

The named edges are:

- Idle to Setup, Setup to Access, Access to Wait, Wait to Done, and Done to Idle or Setup. These are legal.
- Setup to Setup, Setup to Idle, Idle to Access, Done to Access, Wait to anything but Access, and Reset to Access. Each of these is flagged.

Parameters set the select width, the address and data widths, the wait-state limit, and whether unaligned addresses are allowed. A further parameter selects a legacy mode. In that mode there is no ready line, and every access phase completes in a single cycle.

Top module: `apb_rule_monitor`

## Requirements
- R1: While reset is low, `viol_o` is all zero and `err_o` is low. If the first phase seen after reset is Access, bit 0 pulses.
- R2: A Setup phase followed by another Setup phase pulses bit 1. A Setup phase followed by Idle pulses bit 2.
- R3: An Access phase that follows an Idle cycle (not the first cycle after reset) pulses bit 3.
- R4: More than one select bit high in the same cycle pulses bit 4.
- R5: Bit 5 pulses when an Access phase differs from the cycle before it in any of these, while that earlier cycle was Setup or an unfinished Access:
  - address, direction, select, protection or strobes;
  - write data, on writes only.
  Bit 5 also pulses when an unfinished Access is followed by anything other than Access.
- R6: An Access phase directly after a completed Access pulses bit 6.
- R7: Any nonzero strobe during a selected read pulses bit 7.
- R8: With unaligned support off, a selected cycle whose address has a nonzero byte offset within the data word pulses bit 8.
- R9: With unaligned support on, a selected write that enables a byte lane below the address offset pulses bit 10.
- R10: With ready in use, the Access cycle that would be wait state number MAX_WAIT+1 pulses bit 9, once per transfer.
- R11: Each violation bit is high for exactly the one cycle after the offending sample. `err_o` rises together with the first violation and stays high until reset.
- R12: In legacy mode the ready input is ignored. Every Access completes at once, so two Access cycles in a row pulse bit 6 and never bit 5 or bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock; every rule is sampled on its rising edge |
| bus_rst_n | input | 1 | Active-low asynchronous reset; masks all checks |
| sel_i | input | SEL_W | Observed peripheral select vector |
| en_i | input | 1 | Observed enable (access phase) |
| we_i | input | 1 | Observed direction, 1 = write |
| addr_i | input | ADDR_W | Observed byte address |
| wdata_i | input | DATA_W | Observed write data |
| strb_i | input | DATA_W/8 | Observed byte-lane write strobes |
| prot_i | input | 3 | Observed protection attributes |
| ready_i | input | 1 | Observed completer ready (ignored in legacy mode) |
| viol_o | output | 11 | Per-rule violation pulses, bit positions as in the requirements |
| err_o | output | 1 | Sticky any-violation flag |

## Verification
The bound checker watches the following on every cycle:

- multiple select, read strobes, and Setup repeated;
- the wait-limit timeout, using its own run-length counter;
- the reset state, the stickiness of the error flag, and that no violation bit appears without it.

The other rules can only be shown by the bench's scenarios. These are the first-phase rule, idle-to-access, abandoned and completed access edges, field stability and the alignment-dependent strobe rules. The bench sweeps wait-state counts across the limit, every read strobe value, and every byte offset. It runs the default configuration and a legacy, unaligned-capable configuration side by side on the same stimulus.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } phase_e;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_IDLE,
        ST_SETUP,
        ST_WAIT,
        ST_DONE
    } track_e;

    localparam int V_FIRST     = 0;
    localparam int V_SET_SET   = 1;
    localparam int V_SET_IDLE  = 2;
    localparam int V_IDLE_ACC  = 3;
    localparam int V_MULTI_SEL = 4;
    localparam int V_HOLD      = 5;
    localparam int V_ACC_ACC   = 6;
    localparam int V_RD_STRB   = 7;
    localparam int V_ALIGN     = 8;
    localparam int V_TIMEOUT   = 9;
    localparam int V_LANE      = 10;
    localparam int NUM_RULES   = 11;

endpackage

// File: rtl/apb_phase_fsm.sv
module apb_phase_fsm
    import apb_mon_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e cur,
    input  logic   done,
    output logic   first_v,
    output logic   set_set_v,
    output logic   set_idle_v,
    output logic   idle_acc_v,
    output logic   abandon_v,
    output logic   acc_acc_v,
    output logic   held
);

    track_e state_q;
    track_e state_d;

    always_comb begin
        unique case (cur)
            PH_SETUP:  state_d = ST_SETUP;
            PH_ACCESS: state_d = done ? ST_DONE : ST_WAIT;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        first_v    = 1'b0;
        set_set_v  = 1'b0;
        set_idle_v = 1'b0;
        idle_acc_v = 1'b0;
        abandon_v  = 1'b0;
        acc_acc_v  = 1'b0;
        held       = 1'b0;
        unique case (state_q)
            ST_RESET: first_v = (cur == PH_ACCESS);
            ST_IDLE:  idle_acc_v = (cur == PH_ACCESS);
            ST_SETUP: begin
                set_set_v  = (cur == PH_SETUP);
                set_idle_v = (cur == PH_IDLE);
                held       = 1'b1;
            end
            ST_WAIT: begin
                abandon_v = (cur != PH_ACCESS);
                held      = 1'b1;
            end
            ST_DONE:  acc_acc_v = (cur == PH_ACCESS);
            default:  ;
        endcase
    end

endmodule

// File: rtl/apb_hold_check.sv
module apb_hold_check #(
    parameter int SEL_W           = 2,
    parameter int ADDR_W          = 8,
    parameter int DATA_W          = 32,
    parameter int PROT_W          = 3,
    parameter bit ALLOW_UNALIGNED = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                is_access,
    input  logic                held,
    input  logic [SEL_W-1:0]    sel,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W/8-1:0] strb,
    input  logic [PROT_W-1:0]   prot,
    output logic                hold_v,
    output logic                rd_strb_v,
    output logic                align_v,
    output logic                lane_v
);

    localparam int STRB_W    = DATA_W / 8;
    localparam int LANE_BITS = $clog2(STRB_W);

    logic [SEL_W-1:0]  sel_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [STRB_W-1:0] strb_q;
    logic [PROT_W-1:0] prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            strb_q  <= '0;
            prot_q  <= '0;
        end else begin
            sel_q   <= sel;
            we_q    <= we;
            addr_q  <= addr;
            wdata_q <= wdata;
            strb_q  <= strb;
            prot_q  <= prot;
        end
    end

    logic                 active;
    logic                 ctrl_moved;
    logic [LANE_BITS-1:0] offs;

    always_comb begin
        active     = |sel;
        ctrl_moved = (sel != sel_q) || (we != we_q) || (addr != addr_q)
                   || (strb != strb_q) || (prot != prot_q)
                   || (we && (wdata != wdata_q));
        hold_v     = is_access && held && ctrl_moved;
        rd_strb_v  = active && !we && (|strb);
        offs       = addr[LANE_BITS-1:0];
    end

    generate
        if (ALLOW_UNALIGNED) begin : g_unaligned
            logic [STRB_W-1:0] low_lanes;
            always_comb begin
                for (int i = 0; i < STRB_W; i++) begin
                    low_lanes[i] = (i < int'(offs));
                end
            end
            assign align_v = 1'b0;
            assign lane_v  = active && we && (|(strb & low_lanes));
        end else begin : g_aligned
            assign align_v = active && (|offs);
            assign lane_v  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/apb_wait_timer.sv
module apb_wait_timer #(
    parameter int MAX_WAIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic waiting,
    output logic timeout_v
);

    localparam int CNT_W = $clog2(MAX_WAIT + 2);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_WAIT);
    localparam logic [CNT_W-1:0] SAT   = CNT_W'(MAX_WAIT + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!waiting)       cnt_q <= '0;
        else if (cnt_q != SAT)   cnt_q <= cnt_q + 1'b1;
    end

    assign timeout_v = waiting && (cnt_q == LIMIT);

endmodule

// File: rtl/apb_rule_monitor.sv
module apb_rule_monitor
    import apb_mon_pkg::*;
#(
    parameter int SEL_W           = 2,
    parameter int ADDR_W          = 8,
    parameter int DATA_W          = 32,
    parameter int MAX_WAIT        = 3,
    parameter bit ALLOW_UNALIGNED = 1'b0,
    parameter bit HAS_READY       = 1'b1
) (
    input  logic                  bus_clk,
    input  logic                  bus_rst_n,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic                  en_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DATA_W/8-1:0]   strb_i,
    input  logic [2:0]            prot_i,
    input  logic                  ready_i,
    output logic [NUM_RULES-1:0]  viol_o,
    output logic                  err_o
);

    phase_e cur;
    logic   ready_eff;
    logic   done;

    always_comb begin
        if (sel_i == '0) cur = PH_IDLE;
        else if (!en_i)  cur = PH_SETUP;
        else             cur = PH_ACCESS;
        ready_eff = HAS_READY ? ready_i : 1'b1;
        done      = ready_eff;
    end

    logic first_v, set_set_v, set_idle_v, idle_acc_v, abandon_v, acc_acc_v, held;

    apb_phase_fsm u_fsm (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .cur        (cur),
        .done       (done),
        .first_v    (first_v),
        .set_set_v  (set_set_v),
        .set_idle_v (set_idle_v),
        .idle_acc_v (idle_acc_v),
        .abandon_v  (abandon_v),
        .acc_acc_v  (acc_acc_v),
        .held       (held)
    );

    logic hold_v, rd_strb_v, align_v, lane_v;

    apb_hold_check #(
        .SEL_W           (SEL_W),
        .ADDR_W          (ADDR_W),
        .DATA_W          (DATA_W),
        .PROT_W          (3),
        .ALLOW_UNALIGNED (ALLOW_UNALIGNED)
    ) u_hold (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .is_access (cur == PH_ACCESS),
        .held      (held),
        .sel       (sel_i),
        .we        (we_i),
        .addr      (addr_i),
        .wdata     (wdata_i),
        .strb      (strb_i),
        .prot      (prot_i),
        .hold_v    (hold_v),
        .rd_strb_v (rd_strb_v),
        .align_v   (align_v),
        .lane_v    (lane_v)
    );

    logic timeout_v;

    generate
        if (HAS_READY) begin : g_timer
            apb_wait_timer #(.MAX_WAIT(MAX_WAIT)) u_timer (
                .clk       (bus_clk),
                .rst_n     (bus_rst_n),
                .waiting   ((cur == PH_ACCESS) && !ready_eff),
                .timeout_v (timeout_v)
            );
        end else begin : g_no_timer
            assign timeout_v = 1'b0;
        end
    endgenerate

    logic [NUM_RULES-1:0] hits;

    always_comb begin
        hits              = '0;
        hits[V_FIRST]     = first_v;
        hits[V_SET_SET]   = set_set_v;
        hits[V_SET_IDLE]  = set_idle_v;
        hits[V_IDLE_ACC]  = idle_acc_v;
        hits[V_MULTI_SEL] = $countones(sel_i) > 1;
        hits[V_HOLD]      = hold_v || abandon_v;
        hits[V_ACC_ACC]   = acc_acc_v;
        hits[V_RD_STRB]   = rd_strb_v;
        hits[V_ALIGN]     = align_v;
        hits[V_TIMEOUT]   = timeout_v;
        hits[V_LANE]      = lane_v;
    end

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            viol_o <= '0;
            err_o  <= 1'b0;
        end else begin
            viol_o <= hits;
            err_o  <= err_o || (|hits);
        end
    end

endmodule

// File: rtl/apb_rule_monitor_sva.sv
module apb_rule_monitor_sva
    import apb_mon_pkg::*;
#(
    parameter int SEL_W           = 2,
    parameter int ADDR_W          = 8,
    parameter int DATA_W          = 32,
    parameter int MAX_WAIT        = 3,
    parameter bit ALLOW_UNALIGNED = 1'b0,
    parameter bit HAS_READY       = 1'b1
) (
    input logic                 bus_clk,
    input logic                 bus_rst_n,
    input logic [SEL_W-1:0]     sel_i,
    input logic                 en_i,
    input logic                 we_i,
    input logic [DATA_W/8-1:0]  strb_i,
    input logic                 ready_i,
    input logic [NUM_RULES-1:0] viol_o,
    input logic                 err_o
);

    localparam int CW = $clog2(MAX_WAIT + 2);

    logic          was_setup;
    logic [CW-1:0] run_len;
    logic          stalled;

    assign stalled = (sel_i != '0) && en_i && !ready_i;

    always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n) begin
            was_setup <= 1'b0;
            run_len   <= '0;
        end else begin
            was_setup <= (sel_i != '0) && !en_i;
            if (!stalled)                         run_len <= '0;
            else if (run_len != CW'(MAX_WAIT + 1)) run_len <= run_len + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge bus_clk)
        !bus_rst_n |=> (viol_o == '0) && !err_o);

    assert_setup_repeat_R2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        was_setup && (sel_i != '0) && !en_i |=> viol_o[V_SET_SET]);

    assert_multi_select_R4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        ($countones(sel_i) > 1) |=> viol_o[V_MULTI_SEL]);

    assert_read_strobe_R7: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (sel_i != '0) && !we_i && (strb_i != '0) |=> viol_o[V_RD_STRB]);

    assert_sticky_err_R11: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        err_o |=> err_o);

    assert_flag_implies_err_R11: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (viol_o != '0) |-> err_o);

    generate
        if (HAS_READY) begin : g_to
            assert_timeout_R10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
                stalled && (run_len == CW'(MAX_WAIT)) |=> viol_o[V_TIMEOUT]);
        end else begin : g_legacy
            assert_no_timeout_R12: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
                !viol_o[V_TIMEOUT]);
        end
    endgenerate

endmodule

bind apb_rule_monitor apb_rule_monitor_sva #(
    .SEL_W           (SEL_W),
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W),
    .MAX_WAIT        (MAX_WAIT),
    .ALLOW_UNALIGNED (ALLOW_UNALIGNED),
    .HAS_READY       (HAS_READY)
) u_sva (.*);

// File: tb/test_apb_rule_monitor.sv
`timescale 1ns/1ps
module test_apb_rule_monitor;

    localparam int MW = 3;

    localparam logic [10:0] B_FIRST = 11'd1 << 0;
    localparam logic [10:0] B_SS    = 11'd1 << 1;
    localparam logic [10:0] B_SI    = 11'd1 << 2;
    localparam logic [10:0] B_IA    = 11'd1 << 3;
    localparam logic [10:0] B_MULTI = 11'd1 << 4;
    localparam logic [10:0] B_HOLD  = 11'd1 << 5;
    localparam logic [10:0] B_AA    = 11'd1 << 6;
    localparam logic [10:0] B_RDS   = 11'd1 << 7;
    localparam logic [10:0] B_ALN   = 11'd1 << 8;
    localparam logic [10:0] B_TO    = 11'd1 << 9;
    localparam logic [10:0] B_LANE  = 11'd1 << 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = '0;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  strb = '0;
    logic [2:0]  prot = '0;
    logic        rdy = 1'b0;
    logic [10:0] v_m, v_l;
    logic        e_m, e_l;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    apb_rule_monitor #(.MAX_WAIT(MW)) i_apb_rule_monitor (
        .bus_clk(clk), .bus_rst_n(rst_n), .sel_i(sel), .en_i(en), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .strb_i(strb), .prot_i(prot),
        .ready_i(rdy), .viol_o(v_m), .err_o(e_m));

    apb_rule_monitor #(.MAX_WAIT(MW), .ALLOW_UNALIGNED(1'b1), .HAS_READY(1'b0)) i_legacy (
        .bus_clk(clk), .bus_rst_n(rst_n), .sel_i(sel), .en_i(en), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .strb_i(strb), .prot_i(prot),
        .ready_i(rdy), .viol_o(v_l), .err_o(e_l));

    task automatic chk(string tag, logic [10:0] got, logic [10:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic both(string tag, logic [10:0] em, logic [10:0] el);
        chk({tag, " main"}, v_m, em);
        chk({tag, " legacy"}, v_l, el);
    endtask

    task automatic cyc(logic [1:0] s, logic e, logic w, logic [7:0] a,
                       logic [31:0] d, logic [3:0] st, logic r);
        sel = s; en = e; we = w; addr = a; wdata = d; strb = st; rdy = r;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        cyc(2'b00, 1'b0, 1'b0, 8'h00, 32'h0, 4'h0, 1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sel = '0; en = 0; we = 0; addr = '0; wdata = '0; strb = '0; rdy = 0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 reset viol main", v_m, '0);
        chk("R1 reset err main", {10'b0, e_m}, 11'b0);
        chk("R1 reset viol legacy", v_l, '0);
        rst_n = 1'b1;
    endtask

    initial begin
        // R11 legal write, no flags
        do_reset();
        idle();
        both("R11 idle", '0, '0);
        cyc(2'b01, 0, 1, 8'h10, 32'hA5A5_0001, 4'hF, 0);
        both("R11 setup", '0, '0);
        cyc(2'b01, 1, 1, 8'h10, 32'hA5A5_0001, 4'hF, 1);
        both("R11 access", '0, '0);
        idle();
        both("R11 after", '0, '0);
        chk("R11 err stays low", {9'b0, e_m, e_l}, 11'b0);

        // R1 first phase is access
        do_reset();
        cyc(2'b01, 1, 0, 8'h00, 32'h0, 4'h0, 1);
        both("R1 first access", B_FIRST, B_FIRST);
        idle();
        both("R11 pulse drops", '0, '0);
        chk("R11 sticky main", {10'b0, e_m}, 11'd1);
        chk("R11 sticky legacy", {10'b0, e_l}, 11'd1);

        // R2 setup->setup, setup->idle
        do_reset();
        idle();
        cyc(2'b01, 0, 0, 8'h04, 32'h0, 4'h0, 0);
        cyc(2'b01, 0, 0, 8'h04, 32'h0, 4'h0, 0);
        both("R2 setup setup", B_SS, B_SS);
        idle();
        both("R2 setup idle", B_SI, B_SI);

        // R3 idle->access
        do_reset();
        idle();
        cyc(2'b10, 1, 0, 8'h08, 32'h0, 4'h0, 1);
        both("R3 idle access", B_IA, B_IA);

        // R4 multiple select
        do_reset();
        idle();
        cyc(2'b11, 0, 0, 8'h08, 32'h0, 4'h0, 0);
        both("R4 multi sel", B_MULTI, B_MULTI);

        // R5 address moves during transfer
        do_reset();
        idle();
        cyc(2'b01, 0, 1, 8'h10, 32'h1, 4'hF, 0);
        cyc(2'b01, 1, 1, 8'h14, 32'h1, 4'hF, 1);
        both("R5 addr moved", B_HOLD, B_HOLD);
        // R5 write data moves on write
        do_reset();
        idle();
        cyc(2'b01, 0, 1, 8'h10, 32'h1, 4'hF, 0);
        cyc(2'b01, 1, 1, 8'h10, 32'h2, 4'hF, 1);
        both("R5 wdata moved write", B_HOLD, B_HOLD);
        // R5 write data moving on a read is allowed
        do_reset();
        idle();
        cyc(2'b01, 0, 0, 8'h10, 32'h1, 4'h0, 0);
        cyc(2'b01, 1, 0, 8'h10, 32'h2, 4'h0, 1);
        both("R5 wdata moved read", '0, '0);
        // R5 abandoned unfinished access; R12 legacy sees it complete
        do_reset();
        idle();
        cyc(2'b01, 0, 0, 8'h10, 32'h0, 4'h0, 0);
        cyc(2'b01, 1, 0, 8'h10, 32'h0, 4'h0, 0);
        both("R5 wait cycle", '0, '0);
        idle();
        both("R5 R12 abandon", B_HOLD, '0);

        // R6 access after completed access
        do_reset();
        idle();
        cyc(2'b01, 0, 0, 8'h10, 32'h0, 4'h0, 0);
        cyc(2'b01, 1, 0, 8'h10, 32'h0, 4'h0, 1);
        cyc(2'b01, 1, 0, 8'h10, 32'h0, 4'h0, 1);
        both("R6 access access", B_AA, B_AA);

        // R10 / R12 wait-state sweep across the limit
        for (int n = 0; n <= MW + 2; n++) begin
            do_reset();
            idle();
            cyc(2'b01, 0, 1, 8'h20, 32'h7, 4'hF, 0);
            for (int k = 0; k < n; k++) begin
                cyc(2'b01, 1, 1, 8'h20, 32'h7, 4'hF, 0);
                both($sformatf("R10 R12 n=%0d k=%0d", n, k),
                     (k == MW) ? B_TO : 11'd0, (k > 0) ? B_AA : 11'd0);
            end
            cyc(2'b01, 1, 1, 8'h20, 32'h7, 4'hF, 1);
            both($sformatf("R10 R12 n=%0d done", n), '0, (n > 0) ? B_AA : 11'd0);
            chk($sformatf("R10 err n=%0d", n), {10'b0, e_m}, (n > MW) ? 11'd1 : 11'd0);
        end

        // R7 read strobe sweep
        for (int s = 0; s < 16; s++) begin
            do_reset();
            idle();
            cyc(2'b01, 0, 0, 8'h00, 32'h0, 4'(s), 0);
            both($sformatf("R7 setup strb=%0d", s), (s != 0) ? B_RDS : 11'd0,
                 (s != 0) ? B_RDS : 11'd0);
            cyc(2'b01, 1, 0, 8'h00, 32'h0, 4'(s), 1);
            both($sformatf("R7 access strb=%0d", s), (s != 0) ? B_RDS : 11'd0,
                 (s != 0) ? B_RDS : 11'd0);
        end

        // R8 / R9 byte offset sweep with two strobe patterns
        for (int o = 0; o < 4; o++) begin
            for (int p = 0; p < 2; p++) begin
                logic [3:0] st;
                logic [10:0] em, el;
                st = (p == 0) ? 4'hF : 4'((4'hF << o) & 4'hF);
                em = (o != 0) ? B_ALN : 11'd0;
                el = ((st & 4'((1 << o) - 1)) != 0) ? B_LANE : 11'd0;
                do_reset();
                idle();
                cyc(2'b10, 0, 1, 8'h40 + 8'(o), 32'h3, st, 0);
                both($sformatf("R8 R9 setup o=%0d p=%0d", o, p), em, el);
                cyc(2'b10, 1, 1, 8'h40 + 8'(o), 32'h3, st, 1);
                both($sformatf("R8 R9 access o=%0d p=%0d", o, p), em, el);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule